// File: doc/BRIEF.md
# Predicated Source/Destination Step Sequencer

This block produces the element-index schedule for one vector loop. A single predicate bit vector governs two step counters, one for the source side and one for the destination side. Each side has its own zeroing flag. A side with zeroing off lands only on element positions whose predicate bit is set. A side with zeroing on walks every position in order. Because each counter follows its own flag, the two sides can drift apart under the same predicate.

The loop is launched with a one-cycle start pulse. That pulse captures the loop length, the predicate and both zeroing flags. After that the block offers one (source index, destination index) pair per cycle under a valid/ready handshake. Each pair carries a per-side flag telling the consumer that the element is zeroed rather than active.

The loop finishes once a pair is accepted in which either index equals the last element. It also finishes when a side that skips masked-out positions has no set predicate bit left to land on. In both cases the block then raises done, and done stays high until the next start. The block does not read or write registers; it only emits the schedule.

Top module: `step_seq`

## Requirements
- R1: After reset, valid_o and done_o are 0.
- R2: A start with vl_i = 0 raises done_o in the cycle after the start edge and issues no pair.
- R3: A side whose zeroing enable is 0 issues only indices whose predicate bit is 1. It issues them in ascending order and skips none of them.
- R4: A side whose zeroing enable is 1 issues 0, 1, 2, … consecutively. Masked-out positions are included.
- R5: With both zeroing enables 0, srcstep_o equals dststep_o on every issued pair.
- R6: Once a pair is accepted in which either index equals VL-1, no further pair is issued. done_o is 1 from the next cycle.
- R7: When a side with zeroing enable 0 has no set predicate bit at or after its current position (below VL), the loop ends without another pair. done_o rises one cycle after that condition is first presented.
- R8: On each issued pair, a side's zero flag is 1 exactly when that side's zeroing enable is 1 and the predicate bit (bit i of mask_i for index i) at its index is 0.
- R9: While valid_o is 1 and ready_i is 0, the next cycle still shows valid_o = 1 with the same indices and zero flags.
- R10: With ready_i held at 1, a new pair is issued every cycle. No idle cycle occurs between the start edge and the last pair.
- R11: valid_o and done_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a loop; accepted when no loop is running |
| vl_i | input | $clog2(MAXVL+1) | Loop length, 0 to MAXVL |
| mask_i | input | MAXVL | Predicate; bit i governs element i |
| src_zero_en_i | input | 1 | Source side zeroing enable |
| dst_zero_en_i | input | 1 | Destination side zeroing enable |
| ready_i | input | 1 | Consumer accepts the offered pair |
| valid_o | output | 1 | A pair is offered |
| srcstep_o | output | $clog2(MAXVL) | Source element index |
| dststep_o | output | $clog2(MAXVL) | Destination element index |
| src_zflag_o | output | 1 | Source element is zeroed |
| dst_zflag_o | output | 1 | Destination element is zeroed |
| done_o | output | 1 | Loop has ended; held until the next start |

## Verification
The bench sweeps every predicate and every loop length of a six-element configuration under all four zeroing combinations. It runs each case once with the consumer always ready and once with pseudo-random back-pressure. The cases it targets are these:
- Predicates with holes where the flags differ. A design that advanced both counters together would print matching indices there.
- Runs where the zeroing side reaches the last element before the skipping side does. A design that waited for both sides would issue extra pairs.
- All-zero and trailing-zero predicates. A design lacking the early-exit rule would emit indices past the last set bit or hang.
- VL of zero.
- Stalls. A counter that moved during a stall would drop or repeat an element.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } sq_state_e;
endpackage

// File: rtl/step_seq_find.sv
// Lowest set bit of vec within [from, lim), as a combinational priority search.
module step_seq_find #(
    parameter int W  = 64,
    parameter int IW = 6,
    parameter int VW = 7
) (
    input  logic [W-1:0]  vec,
    input  logic [IW-1:0] from,
    input  logic [VW-1:0] lim,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i] && (i >= int'(from)) && (i < int'(lim))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/step_seq_side.sv
// Picks the element one side would issue next from its counter.
module step_seq_side #(
    parameter int W  = 64,
    parameter int IW = 6,
    parameter int VW = 7
) (
    input  logic [W-1:0]  mask,
    input  logic [IW-1:0] cnt,
    input  logic [VW-1:0] vl,
    input  logic          zero_en,
    output logic          have,
    output logic [IW-1:0] pos,
    output logic          zflag,
    output logic          at_last
);
    logic          hit;
    logic [IW-1:0] hit_idx;

    step_seq_find #(.W(W), .IW(IW), .VW(VW)) u_find (
        .vec   (mask),
        .from  (cnt),
        .lim   (vl),
        .found (hit),
        .idx   (hit_idx)
    );

    always_comb begin
        if (zero_en) begin
            have = (VW'(cnt) < vl);
            pos  = cnt;
        end else begin
            have = hit;
            pos  = hit_idx;
        end
        zflag   = zero_en & ~mask[pos];
        at_last = (VW'(pos) + VW'(1)) == vl;
    end
endmodule

// File: rtl/step_seq.sv
module step_seq #(
    parameter int MAXVL = 64,
    localparam int IW = (MAXVL > 1) ? $clog2(MAXVL) : 1,
    localparam int VW = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VW-1:0]    vl_i,
    input  logic [MAXVL-1:0] mask_i,
    input  logic             src_zero_en_i,
    input  logic             dst_zero_en_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IW-1:0]    srcstep_o,
    output logic [IW-1:0]    dststep_o,
    output logic             src_zflag_o,
    output logic             dst_zflag_o,
    output logic             done_o
);
    import step_seq_pkg::*;

    typedef struct packed {
        sq_state_e        st;
        logic [IW-1:0]    src;
        logic [IW-1:0]    dst;
        logic [VW-1:0]    vl;
        logic [MAXVL-1:0] mask;
        logic             sz;
        logic             dz;
    } sq_regs_t;

    sq_regs_t r_q, r_d;

    logic [1:0]          have_w, last_w, zf_w;
    logic [1:0][IW-1:0]  pos_w;
    logic [1:0][IW-1:0]  cnt_w;
    logic [1:0]          zen_w;

    assign cnt_w = {r_q.dst, r_q.src};
    assign zen_w = {r_q.dz, r_q.sz};

    for (genvar g = 0; g < 2; g++) begin : g_side
        step_seq_side #(.W(MAXVL), .IW(IW), .VW(VW)) u_side (
            .mask    (r_q.mask),
            .cnt     (cnt_w[g]),
            .vl      (r_q.vl),
            .zero_en (zen_w[g]),
            .have    (have_w[g]),
            .pos     (pos_w[g]),
            .zflag   (zf_w[g]),
            .at_last (last_w[g])
        );
    end

    logic running, offer;
    assign running = (r_q.st == SQ_RUN);
    assign offer   = running & (&have_w);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SQ_RUN: begin
                if (!(&have_w)) begin
                    r_d.st = SQ_DONE;
                end else if (ready_i) begin
                    if (|last_w) begin
                        r_d.st = SQ_DONE;
                    end else begin
                        r_d.src = pos_w[0] + IW'(1);
                        r_d.dst = pos_w[1] + IW'(1);
                    end
                end
            end
            default: begin
                if (start_i) begin
                    r_d.st   = (vl_i == '0) ? SQ_DONE : SQ_RUN;
                    r_d.src  = '0;
                    r_d.dst  = '0;
                    r_d.vl   = vl_i;
                    r_d.mask = mask_i;
                    r_d.sz   = src_zero_en_i;
                    r_d.dz   = dst_zero_en_i;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign valid_o     = offer;
    assign srcstep_o   = pos_w[0];
    assign dststep_o   = pos_w[1];
    assign src_zflag_o = offer & zf_w[0];
    assign dst_zflag_o = offer & zf_w[1];
    assign done_o      = (r_q.st == SQ_DONE);

    AST_VALID_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && done_o)); // R11
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (VW'(srcstep_o) < r_q.vl) && (VW'(dststep_o) < r_q.vl)); // R3
    AST_SKIP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !r_q.sz) |-> r_q.mask[srcstep_o]); // R3
    AST_SKIP_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !r_q.dz) |-> r_q.mask[dststep_o]); // R3
    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !r_q.sz && !r_q.dz) |-> (srcstep_o == dststep_o)); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o && $stable(srcstep_o) && $stable(dststep_o)
                                   && $stable(src_zflag_o) && $stable(dst_zflag_o)); // R9
    AST_ZERO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && r_q.sz) |=> !valid_o || (srcstep_o == $past(srcstep_o) + IW'(1))); // R4
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && ((VW'(srcstep_o) + VW'(1) == r_q.vl) ||
                                (VW'(dststep_o) + VW'(1) == r_q.vl))) |=> done_o && !valid_o); // R6
    AST_EMPTY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !valid_o) |=> done_o); // R7
endmodule

// File: tb/sim_step_seq.sv
module sim_step_seq;
    localparam int MV = 6;
    localparam int IW = $clog2(MV);
    localparam int VW = $clog2(MV + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [VW-1:0] vl_i = '0;
    logic [MV-1:0] mask_i = '0;
    logic src_zero_en_i = 1'b0, dst_zero_en_i = 1'b0, ready_i = 1'b0;
    logic valid_o, src_zflag_o, dst_zflag_o, done_o;
    logic [IW-1:0] srcstep_o, dststep_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    step_seq #(.MAXVL(MV)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .mask_i(mask_i),
        .src_zero_en_i(src_zero_en_i), .dst_zero_en_i(dst_zero_en_i), .ready_i(ready_i),
        .valid_o(valid_o), .srcstep_o(srcstep_o), .dststep_o(dststep_o),
        .src_zflag_o(src_zflag_o), .dst_zflag_o(dst_zflag_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected schedule
    int es[8], ed[8], ezs[8], ezd[8];
    int en;
    bit eby_last;

    function automatic int next_set(input int from, input int vl, input int m);
        for (int i = from; i < vl; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic build(input int vl, input int m, input bit sz, input bit dz);
        int s = 0, d = 0, ps, pd;
        en = 0; eby_last = 0;
        if (vl == 0) return;
        forever begin
            ps = sz ? s : next_set(s, vl, m);
            pd = dz ? d : next_set(d, vl, m);
            if (ps < 0 || pd < 0) return;
            es[en] = ps; ed[en] = pd;
            ezs[en] = (sz && !m[ps]) ? 1 : 0;
            ezd[en] = (dz && !m[pd]) ? 1 : 0;
            en++;
            if (ps == vl - 1 || pd == vl - 1) begin eby_last = 1; return; end
            s = ps + 1; d = pd + 1;
        end
    endtask

    task automatic run_one(input int vl, input int m, input bit sz, input bit dz, input bit bp);
        int got = 0, cyc, exp_cyc;
        bit pv = 0, pr = 0;
        int p_s = 0, p_d = 0, p_zs = 0, p_zd = 0;
        build(vl, m, sz, dz);
        @(negedge clk);
        start_i = 1'b1; vl_i = VW'(vl); mask_i = MV'(m);
        src_zero_en_i = sz; dst_zero_en_i = dz; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; mask_i = '0; vl_i = '0;
        cyc = 1;
        while (!done_o && cyc < 100) begin
            if (pv && !pr) begin // R9 stall hold
                check(valid_o && srcstep_o == IW'(p_s) && dststep_o == IW'(p_d)
                      && src_zflag_o == p_zs[0] && dst_zflag_o == p_zd[0],
                      "R9 hold", int'(srcstep_o), p_s);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready_i = bp ? lfsr[0] : 1'b1;
            if (valid_o && ready_i) begin
                if (got < en) begin
                    check(int'(srcstep_o) == es[got], sz ? "R4 src" : "R3 R5 src", int'(srcstep_o), es[got]);
                    check(int'(dststep_o) == ed[got], dz ? "R4 dst" : "R3 R5 dst", int'(dststep_o), ed[got]);
                    check(int'(src_zflag_o) == ezs[got] && int'(dst_zflag_o) == ezd[got],
                          "R8 zflags", int'({src_zflag_o, dst_zflag_o}), ezs[got] * 2 + ezd[got]);
                end
                got++;
            end
            pv = valid_o; pr = ready_i;
            p_s = int'(srcstep_o); p_d = int'(dststep_o);
            p_zs = int'(src_zflag_o); p_zd = int'(dst_zflag_o);
            @(negedge clk);
            cyc++;
        end
        ready_i = 1'b0;
        check(done_o && !valid_o, "R11 done", int'(done_o), 1);
        check(got == en, eby_last ? "R6 pair count" : (vl == 0 ? "R2 pair count" : "R7 pair count"), got, en);
        if (!bp) begin
            exp_cyc = 1 + en + ((eby_last || vl == 0) ? 0 : 1);
            check(cyc == exp_cyc, vl == 0 ? "R2 latency" : "R10 cycles", cyc, exp_cyc);
        end
        @(negedge clk);
        check(done_o && !valid_o, "R6 R7 done held", int'(done_o), 1);
    endtask

    initial begin
        #3;
        check(!valid_o && !done_o, "R1 reset", int'({valid_o, done_o}), 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid_o && !done_o, "R1 after reset", int'({valid_o, done_o}), 0);
        // divergence example: mask bits 0,2,3; VL 4
        run_one(4, 'b1101, 1'b1, 1'b0, 1'b0);
        run_one(4, 'b1101, 1'b0, 1'b1, 1'b0);
        for (int bp = 0; bp < 2; bp++)
            for (int f = 0; f < 4; f++)
                for (int vl = 0; vl <= MV; vl++)
                    for (int m = 0; m < (1 << MV); m++)
                        run_one(vl, m, f[0], f[1], bp[0]);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule